// File: doc/BRIEF.md
# Bus-Width Matching Port Adapter

This block sits between a host bus and one port of a memory whose words are built from four equal data lanes (nine bits each by default, a 36-bit word). Two static configuration inputs choose how wide the host bus is: the full word, a half word or a single lane. A fourth setting keeps the port selected but turns all data transfer off, which leaves the port free for a semaphore access while its chip select stays active. In the narrow settings one or two extra low-order address inputs pick the half or the lane that moves.

On a write the block steers host data from the low host bits into the selected lanes and raises only the write enables of those lanes toward the memory. On a read it routes the selected half or lane down to the low host bits and reports, bit by bit, which host data bits it would drive; the undriven bits read as zero. The configuration inputs are registered: a new setting takes effect one clock after it is applied, an access during that settling cycle is dropped, and an access that collides with a setting change is flagged one cycle later.

Top module: `bm_port`

## Requirements
- R1: With configuration {cfg_bm,cfg_sz} = 00 (full width), a write raises all four lane write enables (mem_lane_we = 4'b1111) and passes host_wdata unchanged to mem_wdata; addr_wa and addr_ba have no effect.
- R2: With configuration 10 (half width), a write with addr_wa = 0 raises mem_lane_we = 4'b0011 and with addr_wa = 1 raises 4'b1100; host_wdata[17:0] is placed in both halves of mem_wdata; addr_ba has no effect.
- R3: With configuration 11 (single lane), a write raises exactly one lane write enable, lane number {addr_wa,addr_ba} (00 = bits 8:0 up to 11 = bits 35:27), and host_wdata[8:0] is placed in every lane of mem_wdata.
- R4: With configuration 00, a read drives all 36 host bits (host_oe all ones) with host_rdata equal to mem_rdata.
- R5: With configuration 10, a read returns mem_rdata[17:0] (addr_wa = 0) or mem_rdata[35:18] (addr_wa = 1) on host_rdata[17:0]; host_oe[17:0] is all ones and host_oe[35:18] and host_rdata[35:18] are zero.
- R6: With configuration 11, a read returns lane {addr_wa,addr_ba} of mem_rdata on host_rdata[8:0]; only host_oe[8:0] is set and the bits above are zero.
- R7: With configuration 01 (data transfer off), an active access raises no write enable and no output enable, and host_rdata is zero.
- R8: While acc_en is low, mem_lane_we and host_oe are zero; during a write host_oe is zero.
- R9: In a cycle where the configuration inputs differ from the value captured at the previous clock, any access is ignored (no write enable, no output enable); the new configuration applies from the next cycle.
- R10: mode_err is high for the one cycle that follows a cycle with acc_en high and the configuration inputs changing, and low otherwise.
- R11: After reset the captured configuration is full width and mode_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bm | input | 1 | Width-matching enable (static configuration) |
| cfg_sz | input | 1 | Narrow size select (static configuration) |
| acc_en | input | 1 | Port access active this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| addr_wa | input | 1 | Half-word select (low-order address bit) |
| addr_ba | input | 1 | Lane-within-half select (low-order address bit) |
| host_wdata | input | 36 | Write data from the host |
| host_rdata | output | 36 | Read data toward the host, zero on undriven bits |
| host_oe | output | 36 | Per-bit output enable toward the host |
| mem_rdata | input | 36 | Word read from the memory |
| mem_lane_we | output | 4 | Per-lane write enable to the memory |
| mem_wdata | output | 36 | Lane-steered write data to the memory |
| mode_err | output | 1 | Access collided with a configuration change |

## Verification
A stale or wrongly decoded captured configuration shows up on the very access it affects: the wrong lane write enables, data landing in the wrong lane, or an output-enable vector of the wrong width, all visible in the same cycle since the steering is combinational. A settling cycle that is missed or held too long lets an access through, or drops one, in the cycle right after a change, and mode_err follows one clock behind. The bench walks every setting and every half and lane select with distinct data per lane, so a swapped index shows as a data mismatch rather than slipping through.

// File: rtl/bm_pkg.sv
package bm_pkg;
   // encoding is {cfg_bm, cfg_sz}
   typedef enum logic [1:0] {
      BM_LONG  = 2'b00,
      BM_IOOFF = 2'b01,
      BM_WORD  = 2'b10,
      BM_BYTE  = 2'b11
   } bm_mode_e;
endpackage

// File: rtl/bm_mode_ctl.sv
module bm_mode_ctl
   import bm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_bm,
   input  logic     cfg_sz,
   input  logic     acc_en,
   output bm_mode_e mode,
   output logic     settling,
   output logic     mode_err
);
   bm_mode_e pins;
   bm_mode_e cfg_q;

   assign pins     = bm_mode_e'({cfg_bm, cfg_sz});
   assign settling = (pins != cfg_q);
   assign mode     = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= BM_LONG;
         mode_err <= 1'b0;
      end else begin
         cfg_q    <= pins;
         mode_err <= settling & acc_en;
      end
   end
endmodule

// File: rtl/bm_lane_sel.sv
module bm_lane_sel
   import bm_pkg::*;
#(
   parameter int N_LANES = 4,
   localparam int SEL_W  = $clog2(N_LANES)
)(
   input  bm_mode_e           mode,
   input  logic [SEL_W-1:0]   lane_idx,
   output logic [N_LANES-1:0] lane_mask
);
   localparam int HALF = N_LANES / 2;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      always_comb begin
         unique case (mode)
            BM_LONG:  lane_mask[i] = 1'b1;
            BM_WORD:  lane_mask[i] = ((i >= HALF) == lane_idx[SEL_W-1]);
            BM_BYTE:  lane_mask[i] = (lane_idx == SEL_W'(i));
            default:  lane_mask[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/bm_wr_steer.sv
module bm_wr_steer
   import bm_pkg::*;
#(
   parameter int LANE_W  = 9,
   parameter int N_LANES = 4,
   localparam int DATA_W = LANE_W * N_LANES
)(
   input  bm_mode_e          mode,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int HALF = N_LANES / 2;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      always_comb begin
         unique case (mode)
            BM_WORD: mem_wdata[i*LANE_W +: LANE_W] = host_wdata[(i % HALF)*LANE_W +: LANE_W];
            BM_BYTE: mem_wdata[i*LANE_W +: LANE_W] = host_wdata[LANE_W-1:0];
            default: mem_wdata[i*LANE_W +: LANE_W] = host_wdata[i*LANE_W +: LANE_W];
         endcase
      end
   end
endmodule

// File: rtl/bm_rd_steer.sv
module bm_rd_steer
   import bm_pkg::*;
#(
   parameter int LANE_W  = 9,
   parameter int N_LANES = 4,
   localparam int DATA_W = LANE_W * N_LANES,
   localparam int SEL_W  = $clog2(N_LANES)
)(
   input  bm_mode_e           mode,
   input  logic [SEL_W-1:0]   lane_idx,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  rd_sel,
   output logic [N_LANES-1:0] host_lane_act
);
   localparam int HALF = N_LANES / 2;

   logic [LANE_W-1:0] byte_lane;
   assign byte_lane = mem_rdata[int'(lane_idx)*LANE_W +: LANE_W];

   for (genvar j = 0; j < N_LANES; j++) begin : g_lane
      logic [LANE_W-1:0] word_term;
      logic [LANE_W-1:0] byte_term;
      if (j < HALF) begin : g_lo
         assign word_term = lane_idx[SEL_W-1] ? mem_rdata[(HALF+j)*LANE_W +: LANE_W]
                                              : mem_rdata[j*LANE_W +: LANE_W];
      end else begin : g_hi
         assign word_term = '0;
      end
      if (j == 0) begin : g_first
         assign byte_term = byte_lane;
      end else begin : g_rest
         assign byte_term = '0;
      end

      always_comb begin
         unique case (mode)
            BM_LONG: begin
               rd_sel[j*LANE_W +: LANE_W] = mem_rdata[j*LANE_W +: LANE_W];
               host_lane_act[j]           = 1'b1;
            end
            BM_WORD: begin
               rd_sel[j*LANE_W +: LANE_W] = word_term;
               host_lane_act[j]           = (j < HALF);
            end
            BM_BYTE: begin
               rd_sel[j*LANE_W +: LANE_W] = byte_term;
               host_lane_act[j]           = (j == 0);
            end
            default: begin
               rd_sel[j*LANE_W +: LANE_W] = '0;
               host_lane_act[j]           = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/bm_port.sv
module bm_port
   import bm_pkg::*;
#(
   parameter int LANE_W  = 9,
   parameter int N_LANES = 4,
   localparam int DATA_W = LANE_W * N_LANES
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_bm,
   input  logic               cfg_sz,
   input  logic               acc_en,
   input  logic               acc_wr,
   input  logic               addr_wa,
   input  logic               addr_ba,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [DATA_W-1:0]  host_oe,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [N_LANES-1:0] mem_lane_we,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               mode_err
);
   localparam int SEL_W = $clog2(N_LANES);

   if (N_LANES != 4) begin : g_bad_lanes
      $error("bm_port: N_LANES must be 4 (two select bits)");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("bm_port: LANE_W must be positive");
   end

   bm_mode_e           mode;
   logic               settling;
   logic               acc_ok;
   logic [SEL_W-1:0]   lane_idx;
   logic [N_LANES-1:0] lane_mask;
   logic [N_LANES-1:0] host_lane_act;
   logic [DATA_W-1:0]  rd_sel;

   assign lane_idx = {addr_wa, addr_ba};

   bm_mode_ctl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_bm   (cfg_bm),
      .cfg_sz   (cfg_sz),
      .acc_en   (acc_en),
      .mode     (mode),
      .settling (settling),
      .mode_err (mode_err)
   );

   bm_lane_sel #(.N_LANES(N_LANES)) u_sel (
      .mode      (mode),
      .lane_idx  (lane_idx),
      .lane_mask (lane_mask)
   );

   bm_wr_steer #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_wr (
      .mode       (mode),
      .host_wdata (host_wdata),
      .mem_wdata  (mem_wdata)
   );

   bm_rd_steer #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_rd (
      .mode          (mode),
      .lane_idx      (lane_idx),
      .mem_rdata     (mem_rdata),
      .rd_sel        (rd_sel),
      .host_lane_act (host_lane_act)
   );

   assign acc_ok      = acc_en & ~settling & (mode != BM_IOOFF);
   assign mem_lane_we = (acc_ok & acc_wr) ? lane_mask : '0;

   for (genvar j = 0; j < N_LANES; j++) begin : g_oe
      assign host_oe[j*LANE_W +: LANE_W] = {LANE_W{acc_ok & ~acc_wr & host_lane_act[j]}};
   end

   assign host_rdata = rd_sel & host_oe;
endmodule

// File: rtl/bm_port_chk.sv
module bm_port_chk #(
   parameter int LANE_W  = 9,
   parameter int N_LANES = 4,
   localparam int DATA_W = LANE_W * N_LANES
)(
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_bm,
   input logic               cfg_sz,
   input logic               acc_en,
   input logic               acc_wr,
   input logic [DATA_W-1:0]  host_oe,
   input logic [N_LANES-1:0] mem_lane_we,
   input logic               mode_err
);
   localparam logic [DATA_W-1:0] HALF_OE = DATA_W'({(DATA_W/2){1'b1}});
   localparam logic [DATA_W-1:0] LANE_OE = DATA_W'({LANE_W{1'b1}});

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_byte_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bm && cfg_sz) |-> $onehot0(mem_lane_we));

   p_oe_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bm && !cfg_sz && host_oe != '0) |-> host_oe == HALF_OE);

   p_oe_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bm && cfg_sz && host_oe != '0) |-> host_oe == LANE_OE);

   p_ioff_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bm && cfg_sz) |-> (mem_lane_we == '0 && host_oe == '0));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |-> (mem_lane_we == '0 && host_oe == '0));

   p_write_no_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |-> host_oe == '0);

   p_change_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (!$stable(cfg_bm) || !$stable(cfg_sz))) |-> (mem_lane_we == '0 && host_oe == '0));

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mode_err) |-> $past(acc_en));
endmodule

bind bm_port bm_port_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) chk_i (.*);

// File: tb/bm_port_tb_top.sv
module bm_port_tb_top;
   localparam int CLK_PER  = 10;
   localparam int WATCHDOG = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bm = 1'b0, cfg_sz = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, addr_wa = 1'b0, addr_ba = 1'b0;
   logic [35:0] host_wdata = '0, mem_rdata = '0;
   logic [35:0] host_rdata, host_oe, mem_wdata;
   logic [3:0]  mem_lane_we;
   logic        mode_err;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   bm_port dut_i (.*);

   typedef struct {
      logic [3:0]  we;
      logic [35:0] wd;
      logic [35:0] rd;
      logic [35:0] oe;
      logic        err;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   logic [1:0] mdl_mode = 2'b00;
   logic       prev_hit = 1'b0;

   task automatic chk(input string tag, input string what, input logic [35:0] act, input logic [35:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic op(input logic [1:0] pins, input logic acc, input logic wr,
                     input logic wa, input logic ba, input logic [35:0] hw,
                     input logic [35:0] mr, input string tag);
      exp_t e;
      logic chg, ok;
      logic [3:0]  we_full;
      logic [35:0] wd_full, oe_full, rsel;
      @(negedge clk);
      {cfg_bm, cfg_sz} = pins;
      acc_en = acc; acc_wr = wr; addr_wa = wa; addr_ba = ba;
      host_wdata = hw; mem_rdata = mr;
      chg = (pins != mdl_mode);
      ok  = acc && !chg && (pins != 2'b01);
      case (pins)
         2'b00: begin we_full = 4'b1111; wd_full = hw; oe_full = {36{1'b1}}; rsel = mr; end
         2'b10: begin
            we_full = wa ? 4'b1100 : 4'b0011;
            wd_full = {hw[17:0], hw[17:0]};
            oe_full = {18'd0, {18{1'b1}}};
            rsel    = {18'd0, wa ? mr[35:18] : mr[17:0]};
         end
         2'b11: begin
            we_full = 4'b0001 << {wa, ba};
            wd_full = {4{hw[8:0]}};
            oe_full = {27'd0, {9{1'b1}}};
            rsel    = {27'd0, mr[{wa, ba}*9 +: 9]};
         end
         default: begin we_full = '0; wd_full = '0; oe_full = '0; rsel = '0; end
      endcase
      e.we  = (ok && wr)  ? we_full : 4'b0000;
      e.wd  = wd_full;
      e.oe  = (ok && !wr) ? oe_full : '0;
      e.rd  = rsel & e.oe;
      e.err = prev_hit;
      e.tag = tag;
      prev_hit = chg && acc;
      mdl_mode = pins;
      exp_q.push_back(e);
   endtask

   // monitor: compares a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PER/4);
         if (exp_q.size() > 0) begin
            exp_t e;
            logic [35:0] lmask;
            e = exp_q.pop_front();
            lmask = {{9{e.we[3]}}, {9{e.we[2]}}, {9{e.we[1]}}, {9{e.we[0]}}};
            chk(e.tag, "lane_we", {32'd0, mem_lane_we}, {32'd0, e.we});
            chk(e.tag, "wdata",   mem_wdata & lmask, e.wd & lmask);
            chk(e.tag, "oe",      host_oe, e.oe);
            chk(e.tag, "rdata",   host_rdata, e.rd);
            chk(e.tag, "err",     {35'd0, mode_err}, {35'd0, e.err});
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   localparam logic [35:0] HW = 36'h1_2345_6789 ^ 36'hA_5A5A_5A5A;
   localparam logic [35:0] MR = {9'h1A3, 9'h0C5, 9'h17E, 9'h02B};

   initial begin
      repeat (3) @(negedge clk);
      #(CLK_PER/4);
      chk("R11", "err_in_reset", {35'd0, mode_err}, 36'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: pins at full width after reset cause no settling cycle
      op(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, HW, MR, "R11 idle");
      op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, HW, MR, "R11 R4 read");
      op(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, HW, MR, "R1 write wa/ba=11");
      op(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, ~HW, MR, "R1 write wa/ba=01");
      op(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, HW, ~MR, "R4 read inverted");
      op(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, HW, MR, "R8 idle write");
      // change to half width during an access
      op(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, HW, MR, "R9 change with write");
      op(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, HW, MR, "R10 R2 write lo");
      op(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 36'h0_0003_1F2C, MR, "R2 write hi");
      op(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, HW, MR, "R5 read lo");
      op(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, HW, MR, "R5 read hi");
      op(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, HW, MR, "R8 write no oe");
      // change to single lane with no access
      op(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, HW, MR, "R9 change idle");
      for (int k = 0; k < 4; k++) begin
         op(2'b11, 1'b1, 1'b1, k[1], k[0], HW + 36'(k * 37), MR, "R3 R10 write lane");
      end
      for (int k = 0; k < 4; k++) begin
         op(2'b11, 1'b1, 1'b0, k[1], k[0], HW, MR, "R6 read lane");
      end
      op(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, HW, MR, "R8 idle byte");
      // transfer-off setting
      op(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, HW, MR, "R9 change read");
      op(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, HW, MR, "R10 R7 write off");
      op(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, HW, MR, "R7 read off");
      // back to full width
      op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, HW, MR, "R9 change to long");
      op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, HW, MR, "R10 R4 read after");
      op(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, ~HW, MR, "R1 write after");
      op(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, HW, MR, "R10 final idle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule